// File: doc/BRIEF.md
# Hopping Switching-Frequency Generator

This block produces the start-of-cycle strobe for a flyback switching controller. It runs from a fast system clock and emits one single-clock pulse per switching cycle. The cycle length is a clock count. In the upper band it is centred on 50 kHz. In the lower band, used when the sensed output voltage is low, it is centred on 36 kHz. A slow pseudo-random sequence moves the period around the active centre so that switching energy spreads across a band rather than sitting on a single line. The upper band spans roughly 44 kHz to 56 kHz. The lower band is narrower, about ±2.5 kHz.

Two digital comparator flags choose the band. One reports that the sense voltage has fallen below the lower jump point, near 1.95 V. The other reports that it has risen above the upper jump point, near 2.25 V. Each band is left only on its own exit flag, so the gap between the two jump points acts as hysteresis. Band changes and new hop offsets take effect only where one switching cycle ends and the next begins. The current period is presented alongside the strobe so that downstream duty and blanking logic can scale against it.

Top module: `hfg_top`

## Requirements
- R1: While reset is held and after it is released, `cycle_start` is low, the upper band is active, the hop offset is zero and `period_clks` equals `HI_BASE`. The sequence register is loaded with 7'h01 and the cycle counter is cleared.
- R2: `cycle_start` is exactly one clock wide. Two consecutive strobes are exactly N clocks apart, where N is the `period_clks` value shown with the first of the two strobes.
- R3: While `en` is low no strobe is emitted and the cycle counter is cleared. Band, hop position and period are held. The first clock edge that samples `en` high raises `cycle_start` on that edge, and the period held from before is used.
- R4: The hop source is a 7-bit sequence register L that steps as {L[5:0], L[6]^L[5]}. It steps at the end of every `HOP_CYCLES`-th switching cycle (default 16), counted from reset. Until the first step the offset is zero. After that the period is BASE + floor((L-64)*SPAN/64), where BASE and SPAN are the values of the band that will be active in the coming cycle.
- R5: When the band is upper and `vs_under_flag` is high at a cycle end, the next cycle uses the lower band (`LO_BASE`, `LO_SPAN`).
- R6: When the band is lower, only `vs_over_flag` high at a cycle end returns it to the upper band. Releasing `vs_under_flag` alone keeps the lower band. `vs_over_flag` has no effect in the upper band, and `vs_under_flag` has no effect in the lower band.
- R7: The flags are looked at only on the clock edge that ends a cycle. A pulse on either flag that starts and ends inside a cycle changes neither the band nor the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low stops strobes and clears the cycle counter |
| vs_under_flag | input | 1 | Sense voltage is below the lower jump point |
| vs_over_flag | input | 1 | Sense voltage is above the upper jump point |
| cycle_start | output | 1 | One-clock strobe at the start of each switching cycle |
| period_clks | output | PW | Length in clocks of the cycle that is currently running |

## Verification
The hardest conditions to reach are a hop step that coincides with a band change, and a flag pulse that lands strictly inside a cycle. Both require the stimulus to keep exact count of cycle boundaries. The bench uses small base periods, so dozens of cycles and several sequence steps fit in a short run. It follows every strobe with its own model of the band and the sequence, and it toggles the flags on chosen clocks in the middle of a cycle. Disable windows and a mid-run reset are also placed in the lower band after the offset is live, to show that the held state and the forced return to the upper band behave as stated.

// File: rtl/hfg_pkg.sv
package hfg_pkg;

    typedef enum logic {
        BAND_HI = 1'b0,
        BAND_LO = 1'b1
    } band_e;

    localparam int          SEQ_W    = 7;
    localparam logic [6:0]  SEQ_SEED = 7'h01;

    // Maximal-length 7-bit shift sequence, feedback from the two top bits.
    function automatic logic [6:0] seq_step(input logic [6:0] s);
        return {s[5:0], s[6] ^ s[5]};
    endfunction

endpackage

// File: rtl/hfg_hop_seq.sv
module hfg_hop_seq #(
    parameter int HOP_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_end,
    output logic [6:0] seq_nxt,
    output logic       live_nxt
);
    import hfg_pkg::*;

    localparam int             HW       = (HOP_CYCLES > 1) ? $clog2(HOP_CYCLES) : 1;
    localparam logic [HW-1:0]  HOP_LAST = HW'(HOP_CYCLES - 1);

    typedef struct packed {
        logic [6:0]    seq;
        logic [HW-1:0] hop;
        logic          live;
    } hop_st_t;

    hop_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cyc_end) begin
            if (st_q.hop == HOP_LAST) begin
                st_d.hop  = '0;
                st_d.seq  = seq_step(st_q.seq);
                st_d.live = 1'b1;
            end else begin
                st_d.hop = st_q.hop + HW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{seq: SEQ_SEED, hop: '0, live: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign seq_nxt  = st_d.seq;
    assign live_nxt = st_d.live;

    logic [6:0] seq_q_w;
    assign seq_q_w = st_q.seq;

    AST_SEQ_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_end |=> seq_q_w == $past(seq_q_w)); // R4
    AST_SEQ_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q_w != 7'h00); // R4

endmodule

// File: rtl/hfg_band_sel.sv
module hfg_band_sel (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cyc_end,
    input  logic                 under,
    input  logic                 over,
    output hfg_pkg::band_e       band_nxt
);
    import hfg_pkg::*;

    typedef struct packed {
        band_e band;
    } band_st_t;

    band_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cyc_end) begin
            unique case (st_q.band)
                BAND_HI: if (under) st_d.band = BAND_LO;
                BAND_LO: if (over)  st_d.band = BAND_HI;
                default: st_d.band = BAND_HI;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{band: BAND_HI};
        end else begin
            st_q <= st_d;
        end
    end

    assign band_nxt = st_d.band;

    band_e band_q_w;
    assign band_q_w = st_q.band;

    AST_BAND_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_end |=> band_q_w == $past(band_q_w)); // R7
    AST_LO_HOLDS_WITHOUT_OVER: assert property (@(posedge clk) disable iff (!rst_n)
        (band_q_w == BAND_LO && !over) |=> band_q_w == BAND_LO); // R6
    AST_HI_HOLDS_WITHOUT_UNDER: assert property (@(posedge clk) disable iff (!rst_n)
        (band_q_w == BAND_HI && !under) |=> band_q_w == BAND_HI); // R6

endmodule

// File: rtl/hfg_period_map.sv
module hfg_period_map #(
    parameter int PW      = 12,
    parameter int HI_BASE = 2000,
    parameter int HI_SPAN = 240,
    parameter int LO_BASE = 2778,
    parameter int LO_SPAN = 193
) (
    input  hfg_pkg::band_e   band,
    input  logic [6:0]       seq,
    input  logic             live,
    output logic [PW-1:0]    period
);
    import hfg_pkg::*;

    logic [PW-1:0] cand [2];

    for (genvar b = 0; b < 2; b++) begin : g_band
        localparam int BASE = (b == 0) ? HI_BASE : LO_BASE;
        localparam int SPAN = (b == 0) ? HI_SPAN : LO_SPAN;

        logic signed [31:0] diff_w;
        logic signed [31:0] off_w;
        logic signed [31:0] sum_w;

        always_comb begin
            diff_w = $signed({25'd0, seq}) - 32'sd64;
            off_w  = (diff_w * SPAN) >>> 6;
            sum_w  = BASE + (live ? off_w : 32'sd0);
        end

        assign cand[b] = PW'(sum_w);
    end

    assign period = (band == BAND_LO) ? cand[1] : cand[0];

endmodule

// File: rtl/hfg_top.sv
module hfg_top #(
    parameter int HI_BASE    = 2000,
    parameter int HI_SPAN    = 240,
    parameter int LO_BASE    = 2778,
    parameter int LO_SPAN    = 193,
    parameter int HOP_CYCLES = 16,
    localparam int MAXP = ((HI_BASE + HI_SPAN) > (LO_BASE + LO_SPAN)) ?
                          (HI_BASE + HI_SPAN) : (LO_BASE + LO_SPAN),
    localparam int MINP = ((HI_BASE - HI_SPAN) < (LO_BASE - LO_SPAN)) ?
                          (HI_BASE - HI_SPAN) : (LO_BASE - LO_SPAN),
    localparam int PW   = $clog2(MAXP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          vs_under_flag,
    input  logic          vs_over_flag,
    output logic          cycle_start,
    output logic [PW-1:0] period_clks
);
    import hfg_pkg::*;

    typedef struct packed {
        logic [PW-1:0] cnt;
        logic [PW-1:0] period;
        logic          strobe;
        logic          run;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    logic          cyc_end;
    band_e         band_nxt;
    logic [6:0]    seq_nxt;
    logic          live_nxt;
    logic [PW-1:0] period_nxt;

    assign cyc_end = en && st_q.run && (st_q.cnt == st_q.period - PW'(1));

    hfg_band_sel u_band (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_end  (cyc_end),
        .under    (vs_under_flag),
        .over     (vs_over_flag),
        .band_nxt (band_nxt)
    );

    hfg_hop_seq #(.HOP_CYCLES(HOP_CYCLES)) u_hop (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_end  (cyc_end),
        .seq_nxt  (seq_nxt),
        .live_nxt (live_nxt)
    );

    hfg_period_map #(
        .PW      (PW),
        .HI_BASE (HI_BASE),
        .HI_SPAN (HI_SPAN),
        .LO_BASE (LO_BASE),
        .LO_SPAN (LO_SPAN)
    ) u_map (
        .band   (band_nxt),
        .seq    (seq_nxt),
        .live   (live_nxt),
        .period (period_nxt)
    );

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (!en) begin
            st_d.cnt = '0;
            st_d.run = 1'b0;
        end else if (!st_q.run) begin
            st_d.run    = 1'b1;
            st_d.cnt    = '0;
            st_d.strobe = 1'b1;
        end else if (cyc_end) begin
            st_d.cnt    = '0;
            st_d.strobe = 1'b1;
            st_d.period = period_nxt;
        end else begin
            st_d.cnt = st_q.cnt + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, period: PW'(HI_BASE), strobe: 1'b0, run: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cycle_start = st_q.strobe;
    assign period_clks = st_q.period;

    AST_STROBE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> !cycle_start); // R2
    AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < st_q.period); // R2
    AST_SILENT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !cycle_start); // R3
    AST_PERIOD_AT_START_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_start |-> period_clks == $past(period_clks)); // R7
    AST_PERIOD_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        (period_clks >= PW'(MINP)) && (period_clks <= PW'(MAXP))); // R4

endmodule

// File: tb/tb_hfg_top.sv
module tb_hfg_top;

    localparam int HB = 100;
    localparam int HS = 12;
    localparam int LB = 139;
    localparam int LS = 10;
    localparam int HC = 16;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          under = 1'b0;
    logic          over = 1'b0;
    logic          cycle_start;
    logic [PW-1:0] period_clks;

    always #5 clk = ~clk;

    hfg_top #(
        .HI_BASE(HB), .HI_SPAN(HS), .LO_BASE(LB), .LO_SPAN(LS), .HOP_CYCLES(HC)
    ) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (en),
        .vs_under_flag (under),
        .vs_over_flag  (over),
        .cycle_start   (cycle_start),
        .period_clks   (period_clks)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model built from the requirements
    bit         m_lo;
    logic [6:0] m_seq;
    bit         m_live;
    int         m_hop;
    int         m_per;

    function automatic int ref_period();
        int base = m_lo ? LB : HB;
        int span = m_lo ? LS : HS;
        int off  = ((int'(m_seq) - 64) * span) >>> 6;
        return base + (m_live ? off : 0);
    endfunction

    task automatic mdl_reset();
        m_lo = 1'b0; m_seq = 7'h01; m_live = 1'b0; m_hop = 0; m_per = HB;
    endtask

    task automatic mdl_end();
        if (!m_lo && under)     m_lo = 1'b1;
        else if (m_lo && over)  m_lo = 1'b0;
        if (m_hop == HC - 1) begin
            m_hop  = 0;
            m_seq  = {m_seq[5:0], m_seq[6] ^ m_seq[5]};
            m_live = 1'b1;
        end else begin
            m_hop++;
        end
        m_per = ref_period();
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at the negedge on which a strobe was seen; follows n more cycles.
    // glitch: 0 none, 1 pulse over, 2 pulse under, in the middle of each cycle.
    task automatic follow(input int n, input string req, input int glitch);
        for (int c = 0; c < n; c++) begin
            int extra = 0;
            for (int i = 1; i < m_per; i++) begin
                @(negedge clk);
                if (cycle_start) extra++;
                if (glitch != 0 && i == m_per / 2) begin
                    if (glitch == 1) over = 1'b1; else under = 1'b1;
                end
                if (glitch != 0 && i == m_per / 2 + 1) begin
                    if (glitch == 1) over = 1'b0; else under = 1'b0;
                end
            end
            check(extra == 0, {req, " no strobe inside cycle"}, extra, 0);
            mdl_end();
            @(negedge clk);
            check(cycle_start == 1'b1, {req, " strobe at cycle end"}, int'(cycle_start), 1);
            check(int'(period_clks) == m_per, {req, " period"}, int'(period_clks), m_per);
        end
    endtask

    task automatic t_reset();
        mdl_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(cycle_start == 1'b0, "R1 strobe low in reset", int'(cycle_start), 0);
        check(int'(period_clks) == HB, "R1 period in reset", int'(period_clks), HB);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(cycle_start == 1'b0, "R1 idle after reset", int'(cycle_start), 0);
        check(int'(period_clks) == HB, "R1 period after reset", int'(period_clks), HB);
    endtask

    task automatic t_start();
        en = 1'b1;
        @(negedge clk);
        check(cycle_start == 1'b1, "R3 first strobe after enable", int'(cycle_start), 1);
        check(int'(period_clks) == HB, "R3 period at first strobe", int'(period_clks), HB);
        follow(15, "R1 zero offset", 0);
        follow(1, "R2", 0);
    endtask

    task automatic t_hop();
        follow(40, "R4", 0);
    endtask

    task automatic t_down_and_hold();
        under = 1'b1;
        follow(1, "R5", 0);
        check(m_lo, "R5 model in lower band", int'(m_lo), 1);
        follow(2, "R6 under held in lower band", 0);
        under = 1'b0;
        follow(3, "R6 under released", 0);
        follow(2, "R7 over pulse mid-cycle", 1);
        check(m_lo, "R7 band kept", int'(m_lo), 1);
    endtask

    task automatic t_up_and_hold();
        over = 1'b1;
        follow(1, "R6 return to upper", 0);
        follow(2, "R6 over held in upper band", 0);
        over = 1'b0;
        follow(2, "R7 under pulse mid-cycle", 2);
        check(!m_lo, "R7 upper band kept", int'(m_lo), 0);
    endtask

    task automatic t_disable();
        int seen = 0;
        under = 1'b1;
        follow(1, "R5 before disable", 0);
        under = 1'b0;
        en = 1'b0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (cycle_start) seen++;
        end
        check(seen == 0, "R3 no strobe while disabled", seen, 0);
        check(int'(period_clks) == m_per, "R3 period held while disabled", int'(period_clks), m_per);
        en = 1'b1;
        @(negedge clk);
        check(cycle_start == 1'b1, "R3 restart strobe", int'(cycle_start), 1);
        check(int'(period_clks) == m_per, "R3 held period reused", int'(period_clks), m_per);
        follow(20, "R4 after restart", 0);
    endtask

    task automatic t_reset_mid();
        under = 1'b1;
        follow(1, "R5 before reset", 0);
        under = 1'b0;
        rst_n = 1'b0;
        mdl_reset();
        @(negedge clk);
        check(cycle_start == 1'b0, "R1 strobe cleared by reset", int'(cycle_start), 0);
        check(int'(period_clks) == HB, "R1 period forced by reset", int'(period_clks), HB);
        rst_n = 1'b1;
        @(negedge clk);
        check(cycle_start == 1'b1, "R1 start after reset", int'(cycle_start), 1);
        follow(15, "R1 offset zero again", 0);
        follow(3, "R4 first step after reset", 0);
    endtask

    initial begin
        t_reset();
        t_start();
        t_hop();
        t_down_and_hold();
        t_up_and_hold();
        t_disable();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule